// File: doc/BRIEF.md
# E1 Receive Error Counter Bank

This block holds the receive error counters for eight E1 channels. Each channel has two counters. The first counts frame-word errors, and the second counts CRC-4 block errors. The framer supplies single-cycle error strobes. For frame-word errors, a global two-bit selection decides whether the block counts frame-alignment-word errors, non-alignment-word errors, both, or neither.

Software reaches the counters through a byte-wide register port. To read a counter, software writes any value to the counter's high-byte register. That write copies the live count into a holding buffer and clears the live count, both on the same clock edge. Software then reads the buffer as two bytes, and the counter keeps running while it does so. A counter that fills up stays at its maximum and raises a sticky overflow flag. Each flag drives that channel's interrupt line only when its enable bit in the channel control register is set.

The register port carries single accesses with no flow control, so it uses plain strobes and has no valid/ready handshake. Reads take effect in the same cycle. Writes take effect at the next rising clock edge.

Top module: `e1_err_ctr_bank`

## Requirements
- R1: A register address selects a channel only when bit 7 is 1. Bits 6:4 then give the channel (0 to 7). Bits 3:0 give the register within that channel. Any address with bit 7 at 0 reads 0x00, and writes to it change nothing.
- R2: The frame-word counter is 13 bits wide. It advances by one in each cycle in which a selected strobe is high. `fe_sel[0]` selects the alignment-word strobe and `fe_sel[1]` selects the non-alignment-word strobe. If both selected strobes are high in the same cycle, the counter still advances by exactly one.
- R3: The CRC-4 block counter is 10 bits wide. It advances by one in each cycle in which the channel's CRC strobe is high.
- R4: A write of any data to offset 0x7 copies the live frame-word count into its holding buffer and clears the live count, on the same edge. A write to offset 0x9 does the same for the CRC-4 counter.
- R5: Reads return the holding buffer, never the live count. Offset 0x6 returns bits 7:0 of the frame-word buffer and offset 0x7 returns bits 12:8, with bits 7:5 read as 0. Offset 0x8 returns bits 7:0 of the CRC-4 buffer and offset 0x9 returns bits 9:8, with bits 7:2 read as 0. Writes to offsets 0x6 and 0x8 have no effect.
- R6: If an error strobe arrives in the same cycle as a snapshot write, the newly cleared counter counts it and holds 1.
- R7: A counter that reaches its all-ones value stays there. It sets a sticky overflow flag, and only that counter's snapshot write clears the flag.
- R8: The control register sits at offset 0x5. Bits 3:0 can be written and read back, and bits 7:4 read as 0. Bit 0 enables the frame-word overflow interrupt and bit 1 enables the CRC-4 overflow interrupt. Bits 3:2 are storage only and affect no output.
- R9: `irq[ch]` is high exactly when the channel has at least one overflow flag set whose enable bit is also set.
- R10: A synchronous active-high reset clears every counter, buffer, flag and control register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fe_sel | input | 2 | Frame-word error selection (bit 0: alignment word, bit 1: non-alignment word) |
| fas_err | input | 8 | Per-channel alignment-word error strobes |
| nfas_err | input | 8 | Per-channel non-alignment-word error strobes |
| crc_err | input | 8 | Per-channel CRC-4 block error strobes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| irq | output | 8 | Per-channel overflow interrupt |

## Verification
Several properties are checked on every cycle:
- A counter never advances by more than one per cycle.
- A counter holds its value once saturated.
- An overflow flag stays set until its counter's snapshot.
- A snapshot loads the buffer with the count from the previous cycle and leaves the live counter at zero or one.
- Unmapped reads and padding bits read as zero.
- A channel with both enables clear has its interrupt low.

Other behaviours can only be shown by the bench's scenarios:
- The exact counts under each frame-word selection.
- A strobe that coincides with a snapshot being counted.
- The live count staying invisible until a snapshot is taken.
- Address aliasing being rejected.
- The interplay of the enable bits with flags that are already set.

// File: rtl/e1_ctr_pkg.sv
package e1_ctr_pkg;
  localparam int unsigned NUM_CH  = 8;
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned FE_W    = 13;
  localparam int unsigned CRC_W   = 10;
  localparam int unsigned EN_W    = 4;

  localparam logic [3:0] OFS_CTRL   = 4'h5;
  localparam logic [3:0] OFS_FE_LO  = 4'h6;
  localparam logic [3:0] OFS_FE_HI  = 4'h7;
  localparam logic [3:0] OFS_CRC_LO = 4'h8;
  localparam logic [3:0] OFS_CRC_HI = 4'h9;

  typedef enum logic [1:0] {
    EN_FE  = 2'd0,
    EN_CRC = 2'd1
  } en_bit_e;
endpackage

// File: rtl/e1_sat_ctr.sv
module e1_sat_ctr #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         snap,
  output logic [W-1:0] hold,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] live;
  logic         at_max;

  assign at_max = (live == MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      hold <= '0;
      ovf  <= 1'b0;
    end else if (snap) begin
      hold <= live;
      live <= inc ? ONE : '0;
      ovf  <= 1'b0;
    end else if (inc && !at_max) begin
      live <= live + ONE;
      if (live + ONE == MAXV) ovf <= 1'b1;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !snap |=> (live == $past(live)) || (live == $past(live) + ONE));
  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (at_max && !snap) |=> at_max);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !snap) |=> ovf);
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    snap |=> (hold == $past(live)) && (live <= ONE));
  p_clear_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    snap |=> !ovf);
endmodule

// File: rtl/e1_chan_regs.sv
module e1_chan_regs
  import e1_ctr_pkg::*;
#(
  parameter int unsigned FW = FE_W,
  parameter int unsigned CW = CRC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      fe_sel,
  input  logic            fas,
  input  logic            nfas,
  input  logic            crc,
  input  logic            wr_ctrl,
  input  logic            snap_fe,
  input  logic            snap_crc,
  input  logic [EN_W-1:0] wdata,
  output logic [FW-1:0]   fe_hold,
  output logic [CW-1:0]   crc_hold,
  output logic [EN_W-1:0] ctrl,
  output logic            irq
);
  logic fe_inc, fe_ovf, crc_ovf;

  assign fe_inc = (fas & fe_sel[0]) | (nfas & fe_sel[1]);

  e1_sat_ctr #(.W(FW)) u_fe (
    .clk(clk), .rst(rst), .inc(fe_inc), .snap(snap_fe),
    .hold(fe_hold), .ovf(fe_ovf)
  );

  e1_sat_ctr #(.W(CW)) u_crc (
    .clk(clk), .rst(rst), .inc(crc), .snap(snap_crc),
    .hold(crc_hold), .ovf(crc_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst)          ctrl <= '0;
    else if (wr_ctrl) ctrl <= wdata;
  end

  assign irq = (fe_ovf & ctrl[EN_FE]) | (crc_ovf & ctrl[EN_CRC]);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1:0] == 2'b00) |-> !irq);
  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fe_ovf || crc_ovf));
endmodule

// File: rtl/e1_err_ctr_bank.sv
module e1_err_ctr_bank
  import e1_ctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fe_sel,
  input  logic [NUM_CH-1:0] fas_err,
  input  logic [NUM_CH-1:0] nfas_err,
  input  logic [NUM_CH-1:0] crc_err,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned FE_HI_W  = FE_W - 8;
  localparam int unsigned CRC_HI_W = CRC_W - 8;

  logic            in_win;
  logic [CH_W-1:0] sel_ch;
  logic [3:0]      ofs;

  assign in_win = addr[7];
  assign sel_ch = addr[4 +: CH_W];
  assign ofs    = addr[3:0];

  logic [FE_W-1:0]  fe_hold  [NUM_CH];
  logic [CRC_W-1:0] crc_hold [NUM_CH];
  logic [EN_W-1:0]  ctrl     [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = wr_en && in_win && (sel_ch == CH_W'(ch));

    e1_chan_regs #(.FW(FE_W), .CW(CRC_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .fe_sel   (fe_sel),
      .fas      (fas_err[ch]),
      .nfas     (nfas_err[ch]),
      .crc      (crc_err[ch]),
      .wr_ctrl  (hit && ofs == OFS_CTRL),
      .snap_fe  (hit && ofs == OFS_FE_HI),
      .snap_crc (hit && ofs == OFS_CRC_HI),
      .wdata    (wdata[EN_W-1:0]),
      .fe_hold  (fe_hold[ch]),
      .crc_hold (crc_hold[ch]),
      .ctrl     (ctrl[ch]),
      .irq      (irq[ch])
    );
  end

  always_comb begin
    rdata = 8'h00;
    if (in_win) begin
      unique case (ofs)
        OFS_CTRL:   rdata = {{(8-EN_W){1'b0}}, ctrl[sel_ch]};
        OFS_FE_LO:  rdata = fe_hold[sel_ch][7:0];
        OFS_FE_HI:  rdata = {{(8-FE_HI_W){1'b0}}, fe_hold[sel_ch][FE_W-1:8]};
        OFS_CRC_LO: rdata = crc_hold[sel_ch][7:0];
        OFS_CRC_HI: rdata = {{(8-CRC_HI_W){1'b0}}, crc_hold[sel_ch][CRC_W-1:8]};
        default:    rdata = 8'h00;
      endcase
    end
  end

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !in_win |-> rdata == 8'h00);
  p_fe_pad_r5: assert property (@(posedge clk) disable iff (rst)
    (in_win && ofs == OFS_FE_HI) |-> rdata[7:FE_HI_W] == '0);
  p_crc_pad_r5: assert property (@(posedge clk) disable iff (rst)
    (in_win && ofs == OFS_CRC_HI) |-> rdata[7:CRC_HI_W] == '0);
  p_ctrl_pad_r8: assert property (@(posedge clk) disable iff (rst)
    (in_win && ofs == OFS_CTRL) |-> rdata[7:EN_W] == '0);
endmodule

// File: tb/test_e1_err_ctr_bank.sv
module test_e1_err_ctr_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] fe_sel = 2'b00;
  logic [7:0] fas_err = '0, nfas_err = '0, crc_err = '0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_err_ctr_bank i_e1_err_ctr_bank (
    .clk(clk), .rst(rst), .fe_sel(fe_sel), .fas_err(fas_err),
    .nfas_err(nfas_err), .crc_err(crc_err), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  // hold the selected strobes of channel ch high for n cycles
  task automatic strobe(input int ch, input bit f, input bit nf, input bit c, input int n);
    @(negedge clk);
    fas_err[ch] = f; nfas_err[ch] = nf; crc_err[ch] = c;
    repeat (n) @(negedge clk);
    fas_err[ch] = 1'b0; nfas_err[ch] = 1'b0; crc_err[ch] = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R10 fe lo", 8'h86, 0);
    rd_chk("R10 fe hi", 8'hF7, 0);
    rd_chk("R10 crc lo", 8'hA8, 0);
    rd_chk("R10 ctrl", 8'hC5, 0);
    #1 check("R10 irq", irq, 0);
  endtask

  task automatic t_fe_modes();
    fe_sel = 2'b01;
    strobe(0, 1, 0, 0, 5); strobe(0, 0, 1, 0, 3);
    rd_chk("R5 live hidden", 8'h86, 0);
    wr(8'h87, 8'h5A);
    rd_chk("R2 fas only", 8'h86, 5);
    fe_sel = 2'b10;
    strobe(0, 1, 0, 0, 5); strobe(0, 0, 1, 0, 3);
    wr(8'h87, 8'h00);
    rd_chk("R2 nfas only", 8'h86, 3);
    fe_sel = 2'b11;
    strobe(0, 1, 0, 0, 4); strobe(0, 0, 1, 0, 2); strobe(0, 1, 1, 0, 3);
    wr(8'h87, 8'h00);
    rd_chk("R2 both", 8'h86, 9);
    fe_sel = 2'b00;
    strobe(0, 1, 1, 0, 4);
    wr(8'h87, 8'h00);
    rd_chk("R2 none", 8'h86, 0);
  endtask

  task automatic t_crc_clear();
    strobe(2, 0, 0, 1, 300);
    wr(8'hA9, 8'hFF);
    rd_chk("R3 crc lo", 8'hA8, 300 & 8'hFF);
    rd_chk("R3 crc hi", 8'hA9, 300 >> 8);
    wr(8'hA8, 8'h00);
    rd_chk("R5 low write ignored", 8'hA8, 300 & 8'hFF);
    strobe(2, 0, 0, 1, 7);
    wr(8'hA9, 8'h00);
    rd_chk("R4 cleared then 7", 8'hA8, 7);
    wr(8'hA9, 8'h00);
    rd_chk("R4 empty snapshot", 8'hA8, 0);
  endtask

  task automatic t_coincident();
    fe_sel = 2'b01;
    strobe(4, 1, 0, 0, 6);
    @(negedge clk); wr_en = 1'b1; addr = 8'hC7; fas_err[4] = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00; fas_err[4] = 1'b0;
    rd_chk("R4 snap value", 8'hC6, 6);
    wr(8'hC7, 8'h00);
    rd_chk("R6 coincident strobe", 8'hC6, 1);
  endtask

  task automatic t_decode();
    fe_sel = 2'b01;
    strobe(1, 1, 0, 0, 11);
    wr(8'h17, 8'h00);
    wr(8'h15, 8'h03);
    rd_chk("R1 alias read", 8'h16, 0);
    rd_chk("R1 ctrl untouched", 8'h95, 0);
    wr(8'h97, 8'h00);
    rd_chk("R1 count survived", 8'h96, 11);
  endtask

  task automatic t_sat_irq();
    wr(8'hB5, 8'h02);
    strobe(3, 0, 0, 1, 1030);
    #1 check("R9 crc irq", irq[3], 1);
    wr(8'hB9, 8'h00);
    rd_chk("R7 crc sat lo", 8'hB8, 8'hFF);
    rd_chk("R7 crc sat hi", 8'hB9, 8'h03);
    #1 check("R7 flag cleared", irq[3], 0);
    fe_sel = 2'b01;
    strobe(5, 1, 0, 0, 8194);
    #1 check("R9 masked", irq[5], 0);
    wr(8'hD5, 8'hFC);
    rd_chk("R8 upper zero", 8'hD5, 8'h0C);
    #1 check("R8 bits3:2 no irq", irq[5], 0);
    wr(8'hD5, 8'h01);
    #1 check("R9 enable late", irq[5], 1);
    strobe(5, 1, 0, 0, 2);
    #1 check("R7 sticky", irq[5], 1);
    wr(8'hD7, 8'h00);
    #1 check("R7 snap clears flag", irq[5], 0);
    rd_chk("R7 fe sat lo", 8'hD6, 8'hFF);
    rd_chk("R5 fe sat hi", 8'hD7, 8'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fe_modes();
    t_crc_clear();
    t_coincident();
    t_decode();
    t_sat_irq();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule